// File: doc/BRIEF.md
# Bitplane Fetch Window Sequencer

This block decides, scanline by scanline, when bitplane data fetching is active. It watches a horizontal beam position that advances by one each clock, a programmable window start and window stop position, a line-start pulse and a plane-count field. From these it produces a registered fetch-active flag for the fetch engine, plus the plane counts that the fetch side and the display side should use.

A two-bit state register holds one of four states: idle, armed (the beam has crossed a fixed hardware threshold), fetching (the programmed start was seen while armed) and finished (the programmed stop was seen while fetching). The state moves only to the next state in this order and never skips one. If the start position lies before the threshold, it cannot be matched on the line where arming happens. That line ends armed and fetches nothing. The next line begins armed, so it fetches normally. As a result every other line is blank.

A plane-count value of 7 is treated as 4 planes for fetch scheduling and as 6 planes for the display side. A value of 0 suppresses fetching.

Top module: `bpl_fetch_seq`

## Requirements
- R1: When rst_n is low, the state goes to idle and fetch_active goes to 0. This applies both at start-up and in the middle of a line. The line that follows reset behaves like the first line after power-up.
- R2: The idle state moves to armed on the clock edge that samples hpos equal to THRESH-1 (0x17 by default), so the state is armed from position 0x18 onward. A window start of 0x18 or later is matched on the same line.
- R3: On each clock the state either holds or moves one step in the cyclic order idle, armed, fetching, finished, idle. Idle never goes directly to fetching.
- R4: With win_start at 0x18 or later and win_stop later than win_start, every line fetches. fetch_active is first seen high in the cycle after the edge that samples hpos = win_start+1. It stays high for exactly win_stop - win_start cycles.
- R5: With win_start below 0x18, the first line after reset shows no fetch-active cycles. The line after it fetches for win_stop - win_start cycles, beginning as in R4. The line after that is blank again.
- R6: The finished state returns to idle only on a clock edge where line_start is high. line_start has no effect on any other state.
- R7: plane_sel = 7 gives fetch_planes = 4 and disp_planes = 6. Every other value appears unchanged on both outputs.
- R8: plane_sel = 0 keeps fetch_active low for the whole line, whatever the state.
- R9: fetch_active is a register. It is high only on the clock after a clock in which the state was fetching and plane_sel was nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the beam position advances once per cycle |
| rst_n | input | 1 | Active-low reset |
| line_start | input | 1 | High for the first position of each line |
| hpos | input | HPOS_W | Horizontal beam position |
| win_start | input | HPOS_W | Programmed fetch start position |
| win_stop | input | HPOS_W | Programmed fetch stop position |
| plane_sel | input | 3 | Requested number of bitplanes |
| fetch_active | output | 1 | Registered flag that is high while fetching |
| fetch_planes | output | 3 | Plane count used for fetch scheduling |
| disp_planes | output | 3 | Plane count passed to the display side |

## Verification
A state change takes effect on the edge that samples the matching hpos. fetch_active follows one edge later, so it is first seen high with hpos = win_start+1 already driven, and it is last seen high with hpos = win_stop driven. The bench drives hpos at each falling edge. Just before driving, it reads fetch_active and credits the value to the position it drove previously, so each line's count and first-high position can be compared directly with R4 and R5. The plane-count outputs are combinational and are checked in the same cycle the field is driven.

// File: rtl/bpl_fetch_seq.sv
module bpl_fetch_seq #(
  parameter int HPOS_W = 9,
  parameter int THRESH = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [HPOS_W-1:0] hpos,
  input  logic [HPOS_W-1:0] win_start,
  input  logic [HPOS_W-1:0] win_stop,
  input  logic [2:0]        plane_sel,
  output logic              fetch_active,
  output logic [2:0]        fetch_planes,
  output logic [2:0]        disp_planes
);
  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_ARMED = 2'd1;
  localparam logic [1:0] ST_FETCH = 2'd2;
  localparam logic [1:0] ST_DONE  = 2'd3;
  localparam logic [HPOS_W-1:0] ARM_AT = HPOS_W'(THRESH - 1);

  logic [1:0] state, state_nx;
  logic       step;

  always_comb begin
    case (state)
      ST_IDLE:  step = (hpos == ARM_AT);
      ST_ARMED: step = (hpos == win_start);
      ST_FETCH: step = (hpos == win_stop);
      default:  step = line_start;
    endcase
  end

  assign state_nx = step ? state + 2'd1 : state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      fetch_active <= 1'b0;
    end else begin
      state        <= state_nx;
      fetch_active <= (state == ST_FETCH) && (plane_sel != 3'd0);
    end
  end

  assign fetch_planes = (plane_sel == 3'd7) ? 3'd4 : plane_sel;
  assign disp_planes  = (plane_sel == 3'd7) ? 3'd6 : plane_sel;
endmodule

// File: rtl/bpl_fetch_seq_chk.sv
module bpl_fetch_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_start,
  input logic [1:0] state,
  input logic [2:0] plane_sel,
  input logic       fetch_active,
  input logic [2:0] fetch_planes,
  input logic [2:0] disp_planes
);
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == $past(state)) || (state == $past(state) + 2'd1)); // R3
  AST_IDLE_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |=> (state != 2'd2)); // R3
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && line_start) |=> (state == 2'd0)); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && !line_start) |=> (state == 2'd3)); // R6
  AST_ACTIVE_FROM_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_active |-> ($past(state) == 2'd2)); // R9
  AST_ZERO_PLANES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(plane_sel) == 3'd0) |-> !fetch_active); // R8
  AST_SEVEN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_sel == 3'd7) |-> (fetch_planes == 3'd4 && disp_planes == 3'd6)); // R7
endmodule

bind bpl_fetch_seq bpl_fetch_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .state(state),
  .plane_sel(plane_sel), .fetch_active(fetch_active),
  .fetch_planes(fetch_planes), .disp_planes(disp_planes)
);

// File: tb/bpl_fetch_seq_tb_top.sv
module bpl_fetch_seq_tb_top;
  localparam int LEN = 227;
  localparam int NV  = 7;
  // start, stop, planes, line1 count, line2 count, line3 count
  localparam int VEC [NV][6] = '{
    '{'h38, 'hD0, 4, 152, 152, 152},
    '{'h18, 'h20, 1,   8,   8,   8},
    '{'h10, 'h40, 2,   0,  48,   0},
    '{'h17, 'h30, 3,   0,  25,   0},
    '{'h40, 'h50, 0,   0,   0,   0},
    '{'h20, 'h60, 7,  64,  64,  64},
    '{'h00, 'h10, 5,   0,  16,   0}
  };

  logic clk = 0, rst_n = 0, line_start = 0;
  logic [8:0] hpos = 9'(LEN - 1), win_start = 0, win_stop = 0;
  logic [2:0] plane_sel = 0;
  logic fetch_active;
  logic [2:0] fetch_planes, disp_planes;
  int errors = 0, checks = 0, prev = LEN - 1;

  always #4 clk = ~clk;

  bpl_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .hpos(hpos),
    .win_start(win_start), .win_stop(win_stop), .plane_sel(plane_sel),
    .fetch_active(fetch_active), .fetch_planes(fetch_planes),
    .disp_planes(disp_planes)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; line_start = 0; hpos = 9'(LEN - 1); prev = LEN - 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_line(input int upto, output int cnt, output int first);
    cnt = 0; first = -1;
    for (int h = 0; h < upto; h++) begin
      @(negedge clk);
      if (fetch_active) begin
        cnt++;
        if (first < 0) first = prev;
      end
      hpos = 9'(h); line_start = (h == 0); prev = h;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt, first;
    do_reset();
    @(negedge clk);
    check("R1 reset fetch_active", int'(fetch_active), 0);

    for (int v = 0; v < NV; v++) begin
      win_start = 9'(VEC[v][0]); win_stop = 9'(VEC[v][1]);
      plane_sel = 3'(VEC[v][2]);
      do_reset();
      for (int ln = 0; ln < 3; ln++) begin
        run_line(LEN, cnt, first);
        // R4 normal windows, R5 early-start alternation, R8 zero planes
        check(VEC[v][0] < 'h18 ? "R5 line count" : "R4 line count", cnt, VEC[v][3+ln]);
        if (VEC[v][3+ln] > 0)
          check("R4 first high position", first, VEC[v][0] + 1);
      end
      check("R7 fetch_planes", int'(fetch_planes), VEC[v][2] == 7 ? 4 : VEC[v][2]);
      check("R7 disp_planes", int'(disp_planes), VEC[v][2] == 7 ? 6 : VEC[v][2]);
    end

    // R2: start exactly at the threshold is matched on the first line
    win_start = 9'h18; win_stop = 9'h19; plane_sel = 3'd6;
    do_reset();
    run_line(LEN, cnt, first);
    check("R2 start at threshold", cnt, 1);
    check("R7 plane 6 passthrough", int'(disp_planes), 6);

    // R1: reset mid-window, then a full line is normal again
    win_start = 9'h38; win_stop = 9'hD0; plane_sel = 3'd4;
    do_reset();
    run_line('h60, cnt, first);
    check("R9 active mid-window", int'(fetch_active), 1);
    rst_n = 0;
    #1;
    check("R1 mid-line reset", int'(fetch_active), 0);
    do_reset();
    run_line(LEN, cnt, first);
    check("R1 line after reset", cnt, 152);

    // R6: no line_start pulse means the finished state persists; next line blank
    do_reset();
    run_line(LEN, cnt, first);
    for (int h = 0; h < LEN; h++) begin
      @(negedge clk);
      if (fetch_active) cnt++;
      hpos = 9'(h); line_start = 0; prev = h;
    end
    check("R6 no fetch without line_start", cnt, 152);
    run_line(LEN, cnt, first);
    check("R6 idle after line_start", cnt, 152);

    // R8: plane_sel dropped to 0 mid-window stops fetch_active after one edge
    do_reset();
    run_line('h50, cnt, first);
    plane_sel = 3'd0;
    @(negedge clk);
    @(negedge clk);
    check("R8 zero planes mid-window", int'(fetch_active), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule